// File: doc/BRIEF.md
# Four-Channel Prioritised Memory Mover

The block copies data from one memory location to another without processor help. It has four channels. Software sets each channel up through a small write port by choosing a channel and one of four registers: source, destination, count or control. The block then moves halfwords or words over a simple memory master port. Each unit is one read followed by one write. When a channel has moved its last unit it can raise its own interrupt line.

A channel starts at once when it is enabled, or it waits for one of three events: a vertical-blank tick, a horizontal-blank tick, or its own special request line. Several channels can be ready to run at the same time. The lowest-numbered one gets the bus, and it decides again after every unit. So a more urgent channel can cut into a long run of another channel, and the interrupted channel later continues from where it stopped. The engine marks each bus access as sequential or non-sequential. A non-sequential unit has a two-cycle setup gap in front of it.

Top module: `dma4_engine`

## Requirements
- R1: A written source or destination address always has bit 0 cleared. When a channel is armed in word mode (control bit 10 = 1), its working addresses also get bits [1:0] cleared. The bus never shows an odd address, and in word mode it never shows an address that is not a multiple of 4.
- R2: A count register of zero means 2^(CNT_W-2) units on channels 0 to 2 and 2^CNT_W units on channel 3 (16384 and 65536 with the default CNT_W of 16).
- R3: Each unit is one read from the working source, then one write of the data read to the working destination. Source control is bits [8:7] and destination control is bits [6:5]. The codes are 0 = add the step, 1 = subtract the step, 2 = hold, 3 = add the step (for the destination, reload it on repeat). The step is 2 bytes in halfword mode and 4 bytes in word mode.
- R4: Trigger select is bits [13:12]: 0 = at enable, 1 = vertical-blank tick, 2 = horizontal-blank tick, 3 = the channel's special request line. A trigger other than the selected one has no effect. Special request never starts channel 0.
- R5: Only a write that takes control bit 15 from 0 to 1 copies source, destination and count into the working registers. A control write that keeps bit 15 at 1 does not reload them.
- R6: When several channels are pending, the lowest-numbered one runs first.
- R7: When a run ends and repeat (bit 9) is clear, control bit 15 reads back as 0. When repeat is set, bit 15 stays at 1, the count is reloaded, and the destination is reloaded only when its control code is 3. The channel then waits for its next trigger.
- R8: When a run ends, the channel's interrupt line pulses high for one cycle if control bit 14 is set. It stays low if bit 14 is clear.
- R9: These units are non-sequential (mem_seq = 0): the first unit after a trigger, and any unit whose channel differs from the previous unit's channel. Every other unit is sequential. A non-sequential read comes after at least three cycles without a request. A sequential read comes exactly two cycles after the previous write.
- R10: A higher-priority channel that becomes pending during another channel's unit takes the bus at the next unit boundary. The preempted channel later resumes at its next address with its remaining count.
- R11: After reset no request and no interrupt are active, and every control register reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | 2 | Channel selected for write and control readback |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_ctrl_rd | output | 16 | Control register of the selected channel |
| vblank_tick | input | 1 | Vertical-blank trigger pulse |
| hblank_tick | input | 1 | Horizontal-blank trigger pulse |
| spec_req | input | 4 | Special request line, one per channel |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_wide | output | 1 | 1 for a 32-bit access, 0 for 16-bit |
| mem_seq | output | 1 | Access is sequential |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| irq | output | 4 | Per-channel completion interrupt pulse |

## Verification
Two things can land in the same cycle. A higher-priority channel can be armed while a lower-priority channel is stalled in the middle of a unit. A trigger can also arrive for one channel while another channel is pending or completing. The bench provokes the first case by holding mem_ready low with channel 3 stuck in its first read, arming channel 0, and then releasing the bus. It does the same with a single vertical-blank tick that arms channels 1 and 2 together. A scoreboard holds the exact expected order of accesses, each with its address, direction, width, sequential flag and cycle gap. The bench judges the result against that order: one unit of channel 3, then all of channel 0 (starting non-sequentially), then the rest of channel 3 (starting non-sequentially again).

// File: rtl/dma4_pkg.sv
// Shared encodings for the four-channel memory mover.
// Assumes: control register is 16 bits; config data path is 32 bits.
package dma4_pkg;
    localparam int CTL_W  = 16;
    localparam int CFG_W  = 32;
    localparam int B_DADJ = 5;   // destination step control, 2 bits
    localparam int B_SADJ = 7;   // source step control, 2 bits
    localparam int B_RPT  = 9;
    localparam int B_WIDE = 10;
    localparam int B_TRG  = 12;  // trigger select, 2 bits
    localparam int B_IRQ  = 14;
    localparam int B_EN   = 15;

    typedef enum logic [1:0] {ADJ_INC = 2'd0, ADJ_DEC = 2'd1, ADJ_FIX = 2'd2, ADJ_INC_RLD = 2'd3} adj_e;
    typedef enum logic [1:0] {TRG_NOW = 2'd0, TRG_VBL = 2'd1, TRG_HBL = 2'd2, TRG_SPC = 2'd3} trg_e;
    typedef enum logic [1:0] {SEL_SRC = 2'd0, SEL_DST = 2'd1, SEL_CNT = 2'd2, SEL_CTL = 2'd3} sel_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_READ, ST_WRITE} st_e;
endpackage

// File: rtl/dma4_prio_pick.sv
// Fixed-priority picker: the lowest set request index wins.
// Assumes: N is at least 2.
module dma4_prio_pick #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IDX_W'(i);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma4_channel.sv
// One channel: programmed registers, working copies, trigger latch, completion handling.
// Assumes: unit_done pulses for one cycle when the engine finishes a write for this channel.
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int CH_ID  = 0,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int WCNT_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              spec,
    input  logic              unit_done,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              pend_o,
    output logic              first_o,
    output logic              irq_o
);
    localparam logic [WCNT_W-1:0] ZERO_LEN = (CH_ID == NUM_CH - 1) ?
        (WCNT_W'(1) << CNT_W) : (WCNT_W'(1) << (CNT_W - 2));
    localparam bit SPC_LEGAL = (CH_ID != 0);

    logic [ADDR_W-1:0] src_r, dst_r, wsrc, wdst;
    logic [CNT_W-1:0]  cnt_r;
    logic [WCNT_W-1:0] wcnt, run_len;
    logic [CTL_W-1:0]  ctl_r, new_ctl;
    logic              pend_r, first_r, irq_r, fire, arm_now, wide;

    // Step an address by the width-dependent stride under a control code.
    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0] code, input logic w);
        logic [ADDR_W-1:0] st;
        st = w ? ADDR_W'(4) : ADDR_W'(2);
        case (adj_e'(code))
            ADJ_DEC: return a - st;
            ADJ_FIX: return a;
            default: return a + st;
        endcase
    endfunction

    assign new_ctl = wr_data[CTL_W-1:0];
    assign wide    = ctl_r[B_WIDE];
    assign run_len = (cnt_r == '0) ? ZERO_LEN : {1'b0, cnt_r};
    assign arm_now = wr_en && (sel_e'(wr_sel) == SEL_CTL) && new_ctl[B_EN] && !ctl_r[B_EN];

    // Decode whether the selected trigger event is present this cycle.
    always_comb begin
        case (trg_e'(ctl_r[B_TRG +: 2]))
            TRG_VBL: fire = vblank;
            TRG_HBL: fire = hblank;
            TRG_SPC: fire = spec && SPC_LEGAL;
            default: fire = 1'b0;
        endcase
    end

    // Register file, arming, trigger latch and per-unit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_r <= '0; dst_r <= '0; cnt_r <= '0; ctl_r <= '0;
            wsrc <= '0; wdst <= '0; wcnt <= '0;
            pend_r <= 1'b0; first_r <= 1'b0; irq_r <= 1'b0;
        end else begin
            irq_r <= 1'b0;
            if (ctl_r[B_EN] && !pend_r && fire) begin
                pend_r  <= 1'b1;
                first_r <= 1'b1;
            end
            if (wr_en) begin
                case (sel_e'(wr_sel))
                    SEL_SRC: src_r <= wr_data[ADDR_W-1:0] & ~ADDR_W'(1);
                    SEL_DST: dst_r <= wr_data[ADDR_W-1:0] & ~ADDR_W'(1);
                    SEL_CNT: cnt_r <= wr_data[CNT_W-1:0];
                    default: begin
                        ctl_r <= new_ctl;
                        if (arm_now) begin
                            wsrc    <= new_ctl[B_WIDE] ? {src_r[ADDR_W-1:2], 2'b00} : src_r;
                            wdst    <= new_ctl[B_WIDE] ? {dst_r[ADDR_W-1:2], 2'b00} : dst_r;
                            wcnt    <= run_len;
                            pend_r  <= (trg_e'(new_ctl[B_TRG +: 2]) == TRG_NOW);
                            first_r <= 1'b1;
                        end else if (!new_ctl[B_EN]) begin
                            pend_r <= 1'b0;
                        end
                    end
                endcase
            end
            if (unit_done) begin
                wsrc    <= step_addr(wsrc, ctl_r[B_SADJ +: 2], wide);
                wdst    <= step_addr(wdst, ctl_r[B_DADJ +: 2], wide);
                wcnt    <= wcnt - WCNT_W'(1);
                first_r <= 1'b0;
                if (wcnt == WCNT_W'(1)) begin
                    pend_r <= 1'b0;
                    irq_r  <= ctl_r[B_IRQ];
                    if (ctl_r[B_RPT]) begin
                        wcnt <= run_len;
                        if (adj_e'(ctl_r[B_DADJ +: 2]) == ADJ_INC_RLD)
                            wdst <= wide ? {dst_r[ADDR_W-1:2], 2'b00} : dst_r;
                    end else begin
                        ctl_r[B_EN] <= 1'b0;
                    end
                end
            end
        end
    end

    assign ctl_o   = ctl_r;
    assign src_o   = wsrc;
    assign dst_o   = wdst;
    assign pend_o  = pend_r;
    assign first_o = first_r;
    assign irq_o   = irq_r;
endmodule

// File: rtl/dma4_engine.sv
// Four-channel memory mover top: channel bank, priority pick and bus sequencer.
// Assumes: NUM_CH is a power of two; bus holds an access until mem_ready.
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int SETUP_CYC = 2,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int SU_W = $clog2(SETUP_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CTL_W-1:0]  cfg_ctrl_rd,
    input  logic              vblank_tick,
    input  logic              hblank_tick,
    input  logic [NUM_CH-1:0] spec_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              mem_seq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] irq
);
    logic [CTL_W-1:0]  ctl_w [NUM_CH];
    logic [ADDR_W-1:0] src_w [NUM_CH];
    logic [ADDR_W-1:0] dst_w [NUM_CH];
    logic [NUM_CH-1:0] pend_w, first_w, done_w;
    logic [CH_W-1:0]   gnt, cur, last_ch;
    logic              gnt_any, last_vld, pick_nseq, seq_r;
    logic [SU_W-1:0]   su_cnt;
    logic [DATA_W-1:0] data_r;
    st_e               state;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign done_w[i] = (state == ST_WRITE) && mem_ready && (cur == CH_W'(i));
        dma4_channel #(.CH_ID(i), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cfg_we && (cfg_chan == CH_W'(i))), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
            .vblank(vblank_tick), .hblank(hblank_tick), .spec(spec_req[i]),
            .unit_done(done_w[i]),
            .ctl_o(ctl_w[i]), .src_o(src_w[i]), .dst_o(dst_w[i]),
            .pend_o(pend_w[i]), .first_o(first_w[i]), .irq_o(irq[i])
        );
    end

    dma4_prio_pick #(.N(NUM_CH)) u_pick (.req(pend_w), .gnt_idx(gnt), .gnt_any(gnt_any));

    assign pick_nseq = first_w[gnt] || !last_vld || (gnt != last_ch);

    // Unit sequencer: pick at each boundary, optional setup gap, read, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cur <= '0; last_ch <= '0; last_vld <= 1'b0;
            su_cnt <= '0; data_r <= '0; seq_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (gnt_any) begin
                    cur   <= gnt;
                    seq_r <= !pick_nseq;
                    if (pick_nseq) begin
                        su_cnt <= SU_W'(SETUP_CYC - 1);
                        state  <= ST_SETUP;
                    end else begin
                        state <= ST_READ;
                    end
                end
                ST_SETUP: if (su_cnt == '0) state <= ST_READ;
                          else su_cnt <= su_cnt - SU_W'(1);
                ST_READ: if (mem_ready) begin
                    data_r <= mem_rdata;
                    state  <= ST_WRITE;
                end
                default: if (mem_ready) begin
                    last_ch  <= cur;
                    last_vld <= 1'b1;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_req     = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we      = (state == ST_WRITE);
    assign mem_wide    = ctl_w[cur][B_WIDE];
    assign mem_seq     = seq_r;
    assign mem_addr    = (state == ST_WRITE) ? dst_w[cur] : src_w[cur];
    assign mem_wdata   = data_r;
    assign cfg_ctrl_rd = ctl_w[cfg_chan];
endmodule

// File: rtl/dma4_engine_sva.sv
// Protocol checker for the memory mover, attached to the top by bind.
// Assumes: synchronous active-low reset held for at least one clock.
module dma4_engine_sva #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_wide,
    input logic              mem_seq,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NUM_CH-1:0] irq
);
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !mem_addr[0]); // R1
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_wide |-> mem_addr[1:0] == 2'b00); // R1
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we && !$past(mem_req && mem_we) |-> $past(mem_req && !mem_we && mem_ready)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
    AST_NSEQ_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_req) && !mem_seq |-> !$past(mem_req, 2) && !$past(mem_req, 3)); // R9
    AST_SEQ_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_req) && mem_seq |-> $past(mem_req && mem_we, 2)); // R9
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq)); // R8
    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) |irq |-> $past(mem_req && mem_we && mem_ready)); // R8
endmodule

bind dma4_engine dma4_engine_sva #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_seq(mem_seq), .mem_ready(mem_ready), .mem_addr(mem_addr), .irq(irq)
);

// File: tb/dma4_engine_bench.sv
// Scoreboard bench: driver tasks queue expected bus accesses, a monitor compares them.
module dma4_engine_bench;
    localparam int CNT_W = 10;  // zero-count lengths: 256 (ch0-2), 1024 (ch3)

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic        wide;
        logic        seq;
        int          gap;
        string       req;
    } acc_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_chan = '0, cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] cfg_ctrl_rd;
    logic        vblank_tick = 1'b0, hblank_tick = 1'b0;
    logic [3:0]  spec_req = '0;
    logic        mem_req, mem_we, mem_wide, mem_seq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        ready_r = 1'b1;
    logic [3:0]  irq;

    acc_t        exp_q[$];
    int          nchk = 0, nfail = 0, hs_cnt = 0, cyc = 0, last_hs = 0;
    int          irq_cnt[4] = '{0, 0, 0, 0};
    logic [31:0] last_rd = '0;

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1234_0000;
    endfunction

    assign mem_rdata = pat(mem_addr);

    dma4_engine #(.CNT_W(CNT_W)) u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_ctrl_rd(cfg_ctrl_rd), .vblank_tick(vblank_tick),
        .hblank_tick(hblank_tick), .spec_req(spec_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_seq(mem_seq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(ready_r), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: pop one expected item per completed bus access.
    always @(negedge clk) begin
        acc_t e;
        if (rst_n) begin
            for (int i = 0; i < 4; i++) irq_cnt[i] += int'(irq[i]);
            if (mem_req && ready_r) begin
                hs_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4/R5", "unexpected access", mem_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
                    chk(mem_we == e.we, e.req, "direction", {31'd0, mem_we}, {31'd0, e.we});
                    chk(mem_wide == e.wide, e.req, "width", {31'd0, mem_wide}, {31'd0, e.wide});
                    chk(mem_seq == e.seq, "R9", "seq flag", {31'd0, mem_seq}, {31'd0, e.seq});
                    if (e.gap != 0)
                        chk(cyc - last_hs == e.gap, "R9", "access gap", 32'(cyc - last_hs), 32'(e.gap));
                    if (mem_we) begin
                        if (e.wide) chk(mem_wdata == pat(last_rd), "R3", "write data", mem_wdata, pat(last_rd));
                        else chk(mem_wdata[15:0] == pat(last_rd)[15:0], "R3", "write data",
                                 {16'd0, mem_wdata[15:0]}, {16'd0, pat(last_rd)[15:0]});
                    end else begin
                        last_rd = mem_addr;
                    end
                end
                last_hs = cyc;
            end
        end
    end

    function automatic logic [31:0] adv(input logic [31:0] a, input int m, input int st);
        if (m == 1) return a - 32'(st);
        if (m == 2) return a;
        return a + 32'(st);
    endfunction

    task automatic push_units(input string req, inout logic [31:0] s, inout logic [31:0] d,
                              input int n, input bit wide, input int sm, input int dm, input int first_gap);
        acc_t r;
        for (int k = 0; k < n; k++) begin
            r.we = 1'b0; r.addr = s; r.wide = wide; r.seq = (k != 0);
            r.gap = (k == 0) ? first_gap : 2; r.req = req;
            exp_q.push_back(r);
            r.we = 1'b1; r.addr = d; r.gap = 1;
            exp_q.push_back(r);
            s = adv(s, sm, wide ? 4 : 2);
            d = adv(d, dm, wide ? 4 : 2);
        end
    endtask

    task automatic cfg_write(input int ch, input int sel, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic setup_ch(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
        cfg_write(ch, 0, s);
        cfg_write(ch, 1, d);
        cfg_write(ch, 2, 32'(n));
    endtask

    task automatic read_ctl(input int ch, output logic [15:0] v);
        @(posedge clk); #1;
        cfg_chan = 2'(ch);
        #1 v = cfg_ctrl_rd;
    endtask

    task automatic tick(input int which, input logic [3:0] sp);
        @(posedge clk); #1;
        if (which == 0) vblank_tick = 1'b1;
        else if (which == 1) hblank_tick = 1'b1;
        else spec_req = sp;
        @(posedge clk); #1;
        vblank_tick = 1'b0; hblank_tick = 1'b0; spec_req = '0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] s, d, s0, d0;
        logic [15:0] v;
        int hs0, ic;

        repeat (5) @(posedge clk);
        #1;
        // R11: reset state
        chk(mem_req == 1'b0, "R11", "mem_req in reset", {31'd0, mem_req}, 32'h0);
        chk(irq == 4'd0, "R11", "irq in reset", {28'd0, irq}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            cfg_chan = 2'(c); #1;
            chk(cfg_ctrl_rd == 16'h0, "R11", "ctrl in reset", {16'd0, cfg_ctrl_rd}, 32'h0);
        end
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // R1 R3 R8 R7: ch3 halfword, odd addresses trimmed, immediate, irq on
        s = 32'h0200_0100; d = 32'h0300_0010;
        push_units("R1", s, d, 4, 1'b0, 0, 0, 0);
        setup_ch(3, 32'h0200_0101, 32'h0300_0011, 4);
        cfg_write(3, 3, 32'hC000);
        drain();
        chk(irq_cnt[3] == 1, "R8", "ch3 irq count", 32'(irq_cnt[3]), 32'd1);
        read_ctl(3, v);
        chk(v == 16'h4000, "R7", "ch3 enable cleared", {16'd0, v}, 32'h4000);

        // R1 R3: ch2 word, source down, destination held, no irq
        s = 32'h0400_0004; d = 32'h0500_0000;
        push_units("R3", s, d, 3, 1'b1, 1, 2, 0);
        setup_ch(2, 32'h0400_0006, 32'h0500_0003, 3);
        cfg_write(2, 3, 32'h84C0);
        drain();
        chk(irq_cnt[2] == 0, "R8", "ch2 irq without enable", 32'(irq_cnt[2]), 32'd0);

        // R4 R7: ch1 vblank, repeat, destination reload
        setup_ch(1, 32'h100, 32'h200, 2);
        cfg_write(1, 3, 32'h9260);
        hs0 = hs_cnt;
        tick(1, '0);
        repeat (10) @(posedge clk);
        chk(hs_cnt == hs0, "R4", "hblank ignored by vblank channel", 32'(hs_cnt), 32'(hs0));
        s = 32'h100; d = 32'h200;
        push_units("R4", s, d, 2, 1'b0, 0, 3, 0);
        tick(0, '0);
        drain();
        read_ctl(1, v);
        chk(v == 16'h9260, "R7", "repeat keeps enable", {16'd0, v}, 32'h9260);
        d = 32'h200;
        push_units("R7", s, d, 2, 1'b0, 0, 3, 0);
        tick(0, '0);
        drain();
        cfg_write(1, 3, 32'h0);

        // R4: special request ignored on ch0, honoured on ch2
        setup_ch(0, 32'h600, 32'h680, 1);
        cfg_write(0, 3, 32'hB000);
        hs0 = hs_cnt;
        tick(2, 4'b0001);
        repeat (10) @(posedge clk);
        chk(hs_cnt == hs0, "R4", "special on ch0 ignored", 32'(hs_cnt), 32'(hs0));
        cfg_write(0, 3, 32'h0);
        setup_ch(2, 32'h700, 32'h800, 1);
        cfg_write(2, 3, 32'hB000);
        s = 32'h700; d = 32'h800;
        push_units("R4", s, d, 1, 1'b0, 0, 0, 0);
        tick(2, 4'b0100);
        drain();
        read_ctl(2, v);
        chk(v == 16'h3000, "R7", "ch2 enable cleared", {16'd0, v}, 32'h3000);

        // R5: control rewrite while enabled does not reload working registers
        setup_ch(1, 32'h1000, 32'h2000, 1);
        cfg_write(1, 3, 32'hA000);
        cfg_write(1, 0, 32'h3000);
        cfg_write(1, 3, 32'hA000);
        s = 32'h1000; d = 32'h2000;
        push_units("R5", s, d, 1, 1'b0, 0, 0, 0);
        tick(1, '0);
        drain();

        // R6 R9: ch1 and ch2 fired by the same vblank tick
        setup_ch(1, 32'h10, 32'h20, 2);
        setup_ch(2, 32'h30, 32'h40, 2);
        cfg_write(1, 3, 32'h9000);
        cfg_write(2, 3, 32'h9000);
        s = 32'h10; d = 32'h20;
        push_units("R6", s, d, 2, 1'b0, 0, 0, 0);
        s = 32'h30; d = 32'h40;
        push_units("R6", s, d, 2, 1'b0, 0, 0, 4);
        tick(0, '0);
        drain();
        cfg_write(1, 3, 32'h0);
        cfg_write(2, 3, 32'h0);

        // R10: ch0 armed while ch3 is stalled in its first read
        @(posedge clk); #1 ready_r = 1'b0;
        s = 32'hA00; d = 32'hB00;
        push_units("R10", s, d, 1, 1'b0, 0, 0, 0);
        s0 = 32'hC00; d0 = 32'hD00;
        push_units("R10", s0, d0, 2, 1'b0, 0, 0, 4);
        push_units("R10", s, d, 2, 1'b0, 0, 0, 4);
        setup_ch(3, 32'hA00, 32'hB00, 3);
        cfg_write(3, 3, 32'h8000);
        repeat (6) @(posedge clk);
        setup_ch(0, 32'hC00, 32'hD00, 2);
        cfg_write(0, 3, 32'h8000);
        repeat (3) @(posedge clk);
        #1 ready_r = 1'b1;
        drain();

        // R2: zero count lengths per channel
        ic = irq_cnt[1];
        s = 32'h0; d = 32'h9000;
        push_units("R2", s, d, 1 << (CNT_W - 2), 1'b0, 0, 2, 0);
        setup_ch(1, 32'h0, 32'h9000, 0);
        cfg_write(1, 3, 32'hC040);
        drain();
        chk(irq_cnt[1] == ic + 1, "R2", "ch1 zero-count run ended once", 32'(irq_cnt[1]), 32'(ic + 1));
        ic = irq_cnt[3];
        s = 32'h1_0000; d = 32'h9100;
        push_units("R2", s, d, 1 << CNT_W, 1'b0, 0, 2, 0);
        setup_ch(3, 32'h1_0000, 32'h9100, 0);
        cfg_write(3, 3, 32'hC040);
        drain();
        chk(irq_cnt[3] == ic + 1, "R2", "ch3 zero-count run ended once", 32'(irq_cnt[3]), 32'(ic + 1));
        chk(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'h0);

        finish_run();
    end
endmodule